// File: doc/BRIEF.md
# Phase-Bit Circular Event Queue Writer

This block appends 32-bit event records to a ring buffer that lives in system memory. It holds the ring's descriptor state: a 60-bit base address, a size code, the slot index of the next write, and a one-bit phase value. Each accepted event becomes a record whose top bit is the current phase and whose lower 31 bits carry the event payload. The record goes out as one 32-bit memory write to the slot's address. After a clean write the slot index moves forward, and the phase flips each time the index rolls back to slot zero.

The consumer never shares a head or tail pointer with this writer. It finds fresh records by comparing each record's phase bit against the phase it expects for the current lap. Software loads a new ring through the configuration inputs. Event producers use a request/acknowledge pair. The memory side is a valid/ready write port with an error response. Only one write is outstanding at a time.

Top module: `evq_writer`

## Requirements
- R1: After reset, enq_ack, enq_err and mem_valid are low, and the ring state is base 0, size code 0, slot index 0 and phase 0.
- R2: Each record holds the current phase in bit 31 and enq_data[30:0] in bits 30:0. enq_data[31] is discarded.
- R3: Records go out big-endian. mem_wdata[7:0] carries record bits 31:24, mem_wdata[15:8] carries bits 23:16, mem_wdata[23:16] carries bits 15:8, and mem_wdata[31:24] carries bits 7:0.
- R4: mem_addr equals {cfg_base_hi[27:0], cfg_base_lo} plus four times the slot index, computed modulo 2^60.
- R5: The ring holds 2^(size code + 10) slots, so size code 0 gives 1024 slots and size code 1 gives 2048.
- R6: After every write that completes without error, the slot index advances by one, modulo the ring size.
- R7: When the slot index rolls over to zero, the stored phase inverts. The records of the next lap carry the inverted phase.
- R8: A write answered with mem_err leaves the slot index and the phase unchanged, and enq_err is raised together with enq_ack. The next event goes to the same slot with the same phase.
- R9: A cfg_load pulse captures the base, the size code and the phase from cfg_phase_init, and sets the slot index to 0. A load wins over a write completing in the same cycle.
- R10: mem_valid stays high with stable mem_addr and mem_wdata until mem_ready. mem_valid is low in the cycle after the handshake.
- R11: enq_ack is high for exactly one cycle, the cycle after the memory handshake. A requester that holds enq_valid and enq_data until then, and raises enq_valid again at once for the next event, is served in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load the ring descriptor (one-cycle pulse) |
| cfg_base_hi | input | 32 | Descriptor word whose low 28 bits form base address bits 59:32 |
| cfg_base_lo | input | 32 | Base address bits 31:0 |
| cfg_size | input | 4 | Size code, giving 2^(code+10) slots; codes above the build maximum use the maximum |
| cfg_phase_init | input | 1 | Phase value for the first lap after a load |
| enq_valid | input | 1 | Event request, held until enq_ack |
| enq_data | input | 32 | Event payload; bits 30:0 are stored |
| enq_ack | output | 1 | One-cycle acknowledge after the memory write finishes |
| enq_err | output | 1 | High with enq_ack when the write failed |
| mem_valid | output | 1 | Memory write request |
| mem_addr | output | 60 | Byte address of the record |
| mem_wdata | output | 32 | Record in big-endian byte order |
| mem_ready | input | 1 | Memory accepts and completes the write |
| mem_err | input | 1 | Error response, sampled with mem_ready |

## Verification
The writer is first driven with payloads that have bit 31 set and with alternating-bit patterns. This separates the phase bit from a leaked payload bit and shows any byte-lane swap. Memory latencies of zero and several cycles test whether the request stays stable while stalled and whether the acknowledge waits for the handshake. An error response inserted between clean writes shows whether the slot index and phase are frozen on failure. Full laps of 1024 and 2048 slots, started from both phase values and from an unaligned high base, show whether the rollover point follows the size code, whether the phase inverts there, and whether the address carries into the upper word.

// File: rtl/evq_pkg.sv
package evq_pkg;

    localparam int BASE_HI_W = 28;
    localparam int BASE_LO_W = 32;
    localparam int ADDR_W    = BASE_HI_W + BASE_LO_W;
    localparam int REC_W     = 32;
    localparam int MIN_LOG2  = 10;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_DONE  = 2'd2
    } evq_state_e;

    typedef struct packed {
        logic              phase;
        logic [REC_W-2:0]  payload;
    } evq_rec_t;

    function automatic evq_rec_t make_rec(input logic phase, input logic [REC_W-1:0] data);
        evq_rec_t r;
        r.phase   = phase;
        r.payload = data[REC_W-2:0];
        return r;
    endfunction

    function automatic logic [31:0] to_big_endian(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

endpackage

// File: rtl/evq_ring_state.sv
module evq_ring_state
    import evq_pkg::*;
#(
    parameter int SIZE_W        = 4,
    parameter int MAX_SIZE_CODE = 4,
    localparam int IDX_W        = MIN_LOG2 + MAX_SIZE_CODE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_load,
    input  logic [31:0]       cfg_base_hi,
    input  logic [31:0]       cfg_base_lo,
    input  logic [SIZE_W-1:0] cfg_size,
    input  logic              cfg_phase_init,
    input  logic              advance,
    output logic [ADDR_W-1:0] base,
    output logic [IDX_W-1:0]  slot,
    output logic              phase
);
    logic [SIZE_W-1:0] size_q;
    logic [SIZE_W-1:0] size_eff;
    logic [IDX_W-1:0]  slot_mask;
    logic [IDX_W-1:0]  slot_next;

    always_comb begin
        size_eff = (cfg_size > SIZE_W'(MAX_SIZE_CODE)) ? SIZE_W'(MAX_SIZE_CODE) : cfg_size;
    end

    always_comb begin
        for (int i = 0; i < IDX_W; i++) begin
            slot_mask[i] = (i < (MIN_LOG2 + int'(size_q)));
        end
        slot_next = (slot + 1'b1) & slot_mask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base   <= '0;
            size_q <= '0;
            slot   <= '0;
            phase  <= 1'b0;
        end else if (cfg_load) begin
            base   <= {cfg_base_hi[BASE_HI_W-1:0], cfg_base_lo};
            size_q <= size_eff;
            slot   <= '0;
            phase  <= cfg_phase_init;
        end else if (advance) begin
            slot <= slot_next;
            if (slot_next == '0) begin
                phase <= ~phase;
            end
        end
    end
endmodule

// File: rtl/evq_rec_fmt.sv
module evq_rec_fmt
    import evq_pkg::*;
#(
    parameter int IDX_W = 14
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  slot,
    input  logic              phase,
    input  logic [REC_W-1:0]  data,
    output logic [ADDR_W-1:0] addr,
    output logic [31:0]       wdata
);
    localparam int PAD_W = ADDR_W - IDX_W - 2;
    evq_rec_t rec;

    always_comb begin
        rec   = make_rec(phase, data);
        addr  = base + {{PAD_W{1'b0}}, slot, 2'b00};
        wdata = to_big_endian(rec);
    end
endmodule

// File: rtl/evq_ctrl.sv
module evq_ctrl
    import evq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             enq_valid,
    input  logic [REC_W-1:0] enq_data,
    input  logic             mem_ready,
    input  logic             mem_err,
    output logic             mem_valid,
    output logic             enq_ack,
    output logic             enq_err,
    output logic             advance,
    output logic [REC_W-1:0] data_q
);
    evq_state_e st;
    logic       err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            err_q  <= 1'b0;
            data_q <= '0;
        end else begin
            case (st)
                ST_IDLE: if (enq_valid) begin
                    data_q <= enq_data;
                    st     <= ST_WRITE;
                end
                ST_WRITE: if (mem_ready) begin
                    err_q <= mem_err;
                    st    <= ST_DONE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_valid = (st == ST_WRITE);
        advance   = mem_valid && mem_ready && !mem_err;
        enq_ack   = (st == ST_DONE);
        enq_err   = enq_ack && err_q;
    end
endmodule

// File: rtl/evq_writer.sv
module evq_writer
    import evq_pkg::*;
#(
    parameter int SIZE_W        = 4,
    parameter int MAX_SIZE_CODE = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_load,
    input  logic [31:0]       cfg_base_hi,
    input  logic [31:0]       cfg_base_lo,
    input  logic [SIZE_W-1:0] cfg_size,
    input  logic              cfg_phase_init,
    input  logic              enq_valid,
    input  logic [31:0]       enq_data,
    output logic              enq_ack,
    output logic              enq_err,
    output logic              mem_valid,
    output logic [59:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ready,
    input  logic              mem_err
);
    localparam int IDX_W = MIN_LOG2 + MAX_SIZE_CODE;

    logic              advance;
    logic [REC_W-1:0]  data_q;
    logic [ADDR_W-1:0] base;
    logic [IDX_W-1:0]  slot;
    logic              phase;

    evq_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .enq_valid (enq_valid),
        .enq_data  (enq_data),
        .mem_ready (mem_ready),
        .mem_err   (mem_err),
        .mem_valid (mem_valid),
        .enq_ack   (enq_ack),
        .enq_err   (enq_err),
        .advance   (advance),
        .data_q    (data_q)
    );

    evq_ring_state #(
        .SIZE_W        (SIZE_W),
        .MAX_SIZE_CODE (MAX_SIZE_CODE)
    ) u_state (
        .clk            (clk),
        .rst            (rst),
        .cfg_load       (cfg_load),
        .cfg_base_hi    (cfg_base_hi),
        .cfg_base_lo    (cfg_base_lo),
        .cfg_size       (cfg_size),
        .cfg_phase_init (cfg_phase_init),
        .advance        (advance),
        .base           (base),
        .slot           (slot),
        .phase          (phase)
    );

    evq_rec_fmt #(
        .IDX_W (IDX_W)
    ) u_fmt (
        .base  (base),
        .slot  (slot),
        .phase (phase),
        .data  (data_q),
        .addr  (mem_addr),
        .wdata (mem_wdata)
    );
endmodule

// File: rtl/evq_writer_chk.sv
module evq_writer_chk (
    input logic        clk,
    input logic        rst,
    input logic        cfg_load,
    input logic        enq_ack,
    input logic        enq_err,
    input logic        mem_valid,
    input logic        mem_ready,
    input logic [59:0] mem_addr,
    input logic [31:0] mem_wdata
);
    AST_ACK_AFTER_HANDSHAKE: assert property (@(posedge clk) disable iff (rst)
        enq_ack |-> $past(mem_valid && mem_ready)); // R11

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        enq_ack |=> !enq_ack); // R11

    AST_ERR_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
        enq_err |-> enq_ack); // R8

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready && !cfg_load) |=>
            (mem_valid && $stable(mem_addr) && $stable(mem_wdata))); // R10

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_ready) |=> !mem_valid); // R10
endmodule

bind evq_writer evq_writer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_load  (cfg_load),
    .enq_ack   (enq_ack),
    .enq_err   (enq_err),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
);

// File: tb/sim_evq_writer.sv
module sim_evq_writer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_load = 1'b0;
    logic [31:0] cfg_base_hi = '0;
    logic [31:0] cfg_base_lo = '0;
    logic [3:0]  cfg_size = '0;
    logic        cfg_phase_init = 1'b0;
    logic        enq_valid = 1'b0;
    logic [31:0] enq_data = '0;
    logic        enq_ack, enq_err, mem_valid;
    logic [59:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ready = 1'b0;
    logic        mem_err = 1'b0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic timed_out = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    evq_writer u0 (.*);

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rec_of(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    task automatic load(input logic [31:0] hi, input logic [31:0] lo,
                        input logic [3:0] sz, input logic ph);
        @(negedge clk);
        cfg_base_hi = hi; cfg_base_lo = lo; cfg_size = sz; cfg_phase_init = ph;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    // one event: latency in cycles before mem_ready, optional error response
    task automatic enq(input logic [31:0] d, input int lat, input logic err,
                       output logic [59:0] a, output logic [31:0] w, output logic e);
        logic early_ack;
        enq_valid = 1'b1; enq_data = d;
        while (!mem_valid && !timed_out) @(negedge clk);
        a = mem_addr; w = mem_wdata;
        early_ack = 1'b0;
        for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            if (enq_ack) early_ack = 1'b1;
            if (!mem_valid || mem_addr !== a || mem_wdata !== w) begin
                check("R10 held", {mem_valid, mem_addr}, {1'b1, a});
            end
        end
        if (early_ack) check("R11 early ack", 1, 0);
        mem_ready = 1'b1; mem_err = err;
        @(negedge clk);
        mem_ready = 1'b0; mem_err = 1'b0;
        e = enq_err;
        if (!enq_ack || mem_valid) check("R11 ack/R10 drop", {enq_ack, mem_valid}, 2'b10);
        enq_valid = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 ack", enq_ack, 0);
        check("R1 err", enq_err, 0);
        check("R1 mem_valid", mem_valid, 0);
    endtask

    task automatic t_after_reset_write();
        logic [59:0] a; logic [31:0] w; logic e;
        enq(32'hFFFF_0001, 0, 0, a, w, e);
        check("R1 base/slot", a, 0);
        check("R1/R2 phase0 data", rec_of(w), 32'h7FFF_0001);
        check("R3 byte lanes", w, 32'h0100_FF7F);
        check("R8 no err", e, 0);
    endtask

    task automatic t_format_addr();
        logic [59:0] a; logic [31:0] w; logic e;
        logic [59:0] base;
        load(32'hF123_4567, 32'hFFFF_FFF8, 4'd0, 1'b1);
        base = {28'h123_4567, 32'hFFFF_FFF8};
        enq(32'h8000_0000, 3, 0, a, w, e);
        check("R9 slot0 after load", a, base);
        check("R2 phase from init, bit31 dropped", rec_of(w), 32'h8000_0000);
        enq(32'h5555_AAAA, 0, 0, a, w, e);
        check("R6 R4 slot1", a, base + 60'd4);
        check("R3 pattern", w, 32'hAAAA_55D5);
        enq(32'h0000_0003, 5, 0, a, w, e);
        check("R4 carry into high word", a, base + 60'd8);
        check("R2 data", rec_of(w), 32'h8000_0003);
    endtask

    task automatic t_error();
        logic [59:0] a, a2; logic [31:0] w; logic e;
        load(32'h0, 32'h1000, 4'd0, 1'b0);
        enq(32'h11, 0, 0, a, w, e);
        enq(32'h22, 2, 1, a, w, e);
        check("R8 err flag", e, 1);
        check("R8 failed slot", a, 60'h1004);
        enq(32'h33, 0, 0, a2, w, e);
        check("R8 same slot retried", a2, 60'h1004);
        check("R8 same phase", rec_of(w), 32'h0000_0033);
        check("R8 clean ack", e, 0);
    endtask

    task automatic t_wrap(input logic [3:0] sz, input logic ph);
        logic [59:0] a; logic [31:0] w; logic e;
        int n;
        n = 1024 << sz;
        load(32'h0, 32'h0, sz, ph);
        for (int i = 0; i < n - 1 && !timed_out; i++) enq(i, 0, 0, a, w, e);
        enq(32'h0ABC, 0, 0, a, w, e);
        check("R5 last slot", a, 60'(4 * (n - 1)));
        check("R7 last lap phase", rec_of(w), {ph, 31'h0ABC});
        enq(32'h0DEF, 0, 0, a, w, e);
        check("R5 R6 wrap to slot0", a, 0);
        check("R7 phase inverted", rec_of(w), {~ph, 31'h0DEF});
    endtask

    task automatic t_load_wins();
        logic [59:0] a; logic [31:0] w; logic e;
        load(32'h0, 32'h200, 4'd0, 1'b0);
        enq(32'h1, 0, 0, a, w, e);
        // load coincides with handshake of the next write
        enq_valid = 1'b1; enq_data = 32'h2;
        while (!mem_valid && !timed_out) @(negedge clk);
        mem_ready = 1'b1;
        cfg_base_hi = 0; cfg_base_lo = 32'h800; cfg_size = 0; cfg_phase_init = 1'b1;
        cfg_load = 1'b1;
        @(negedge clk);
        mem_ready = 1'b0; cfg_load = 1'b0; enq_valid = 1'b0;
        enq(32'h3, 0, 0, a, w, e);
        check("R9 load wins slot", a, 60'h800);
        check("R9 load wins phase", rec_of(w), 32'h8000_0003);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_after_reset_write();
        t_format_addr();
        t_error();
        t_wrap(4'd0, 1'b0);
        t_wrap(4'd1, 1'b1);
        t_load_wins();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        timed_out = 1'b1;
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=done", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule